// File: doc/BRIEF.md
# Serial Memory Slave Pause Gate

This block sits between the pins of a serial memory slave and the command engine behind it. It lets a bus master freeze a transfer part-way through without losing it. When the active-low pause pin is asserted while the slave is selected, the gate stops passing serial clock edges to the core and releases the serial data output driver. Every partly shifted opcode, address or program buffer inside the core stays exactly where it was. When the pause is released, the core carries on from the next bit.

All pins are brought into a faster system clock through synchronizer chains. Rising and falling serial clock events are found by edge detection and then handed to the core as single-cycle enables. Pause entry and exit only take effect while the serial clock is low. A pause edge that arrives while the clock is high is recorded as pending and is resolved on the next falling clock edge.

The core also receives the synchronized select and data levels. It gets two deselect pulses that are mutually exclusive: one for a transfer that ended normally and one for a transfer whose select was released while it was paused. The core must discard a transfer flagged by the second pulse.

Top module: `spi_hold_gate`

## Requirements
- R1: Out of reset `paused`, `core_rise_en`, `core_fall_en`, `core_xfer_done`, `core_xfer_abort` and `sdo_oe` are all 0, and `core_selected` is 0.
- R2: A falling edge on `spi_holdn` while selected and with `spi_sclk` low sets `paused` exactly SYNC_STAGES+1 system cycles after the pin change.
- R3: A falling edge on `spi_holdn` while selected and with `spi_sclk` high leaves `paused` at 0 until the next falling serial clock edge. That falling edge is still delivered on `core_fall_en`, and `paused` is set afterwards.
- R4: A rising edge on `spi_holdn` with `spi_sclk` low clears `paused` at once (after synchronization).
- R5: A rising edge on `spi_holdn` with `spi_sclk` high keeps `paused` at 1 until the next falling serial clock edge. That edge is not delivered to the core, and `paused` clears afterwards.
- R6: While `paused` is 1, `core_rise_en` and `core_fall_en` stay 0, so neither serial clock edges nor data reach the core.
- R7: `sdo_oe` equals `core_drive_req` AND selected (`spi_csn` synchronized low) AND NOT `paused`.
- R8: Pause pin edges seen while `spi_csn` is high have no effect. Being deselected clears `paused` and any pending entry or exit, and selecting with `spi_holdn` already low does not pause.
- R9: Each rising edge of synchronized `spi_csn` gives a one-cycle pulse: `core_xfer_abort` if `paused` was 1 at that edge, otherwise `core_xfer_done`. The two never fire together.
- R10: While selected and not paused, each serial clock rise and fall gives exactly one single-cycle pulse on `core_rise_en` or `core_fall_en` respectively. No edge pulses are given while deselected.
- R11: `core_sdi` follows `spi_sdi` after SYNC_STAGES system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select pin, active low |
| spi_sclk | input | 1 | Serial clock pin |
| spi_sdi | input | 1 | Serial data input pin |
| spi_holdn | input | 1 | Pause pin, active low |
| core_drive_req | input | 1 | Core wants to drive the serial output |
| paused | output | 1 | Pause currently in force |
| core_rise_en | output | 1 | Qualified serial clock rising-edge enable |
| core_fall_en | output | 1 | Qualified serial clock falling-edge enable |
| core_sdi | output | 1 | Synchronized serial data level |
| core_selected | output | 1 | Synchronized select, active high |
| core_xfer_done | output | 1 | Deselect pulse, transfer not paused |
| core_xfer_abort | output | 1 | Deselect pulse while paused |
| sdo_oe | output | 1 | Output enable for the serial data driver |

## Verification
The bench builds the gate with SYNC_STAGES set to 3 rather than the default 2. This shows that the R2 latency check and the R11 data path follow the parameter instead of a fixed delay. Each pin change is held for eight system cycles, which is longer than the deepest synchronizer-plus-state path, so each step can be compared with a step-level reference model. Random steps toggle one pin at a time, so a pause edge is often taken while the clock is high. This lets a pending entry be cancelled by a release, and lets a deselect land on a paused or pending transfer.

// File: rtl/hold_gate_pkg.sv
package hold_gate_pkg;

  // Pin group carried through the synchronizer chain as one vector
  typedef struct packed {
    logic csn;
    logic sclk;
    logic sdi;
    logic holdn;
  } pin_bus_t;

  localparam int PIN_W = $bits(pin_bus_t);

  // Reset value of the pins: deselected, clock low, data low, not paused
  localparam pin_bus_t PIN_IDLE = '{csn: 1'b1, sclk: 1'b0, sdi: 1'b0, holdn: 1'b1};

  // Edge pair from an edge detector
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_pair_t;

  // Pause state kept by the controller
  typedef struct packed {
    logic held;
    logic pend_enter;
    logic pend_exit;
  } pause_state_t;

endpackage

// File: rtl/hold_gate_sync.sv
module hold_gate_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];

endmodule

// File: rtl/hold_gate_edge.sv
module hold_gate_edge #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= level;
  end

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise[b] = level[b] & ~prev[b];
      assign fall[b] = ~level[b] & prev[b];
    end
  endgenerate

endmodule

// File: rtl/hold_gate_ctl.sv
module hold_gate_ctl
  import hold_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         selected,
  input  logic         sclk_lvl,
  input  logic         sclk_fall,
  input  logic         hold_fall,
  input  logic         hold_rise,
  output pause_state_t state
);

  pause_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!selected) begin
      st_d = '0;
    end else if (hold_fall) begin
      if (!sclk_lvl) begin
        st_d.held       = 1'b1;
        st_d.pend_enter = 1'b0;
      end else begin
        st_d.pend_enter = 1'b1;
      end
      st_d.pend_exit = 1'b0;
    end else if (hold_rise) begin
      if (!sclk_lvl) begin
        st_d.held      = 1'b0;
        st_d.pend_exit = 1'b0;
      end else begin
        st_d.pend_exit = 1'b1;
      end
      st_d.pend_enter = 1'b0;
    end else if (sclk_fall) begin
      if (st_q.pend_enter) begin
        st_d.held       = 1'b1;
        st_d.pend_enter = 1'b0;
      end else if (st_q.pend_exit) begin
        st_d.held      = 1'b0;
        st_d.pend_exit = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import hold_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn,
  input  logic spi_sclk,
  input  logic spi_sdi,
  input  logic spi_holdn,
  input  logic core_drive_req,
  output logic paused,
  output logic core_rise_en,
  output logic core_fall_en,
  output logic core_sdi,
  output logic core_selected,
  output logic core_xfer_done,
  output logic core_xfer_abort,
  output logic sdo_oe
);

  localparam int EDGE_W = 3;  // csn, sclk, holdn

  pin_bus_t pins_raw, pins_s;
  logic [EDGE_W-1:0] lvl, rise, fall;
  pause_state_t st;
  logic sel;

  assign pins_raw = '{csn: spi_csn, sclk: spi_sclk, sdi: spi_sdi, holdn: spi_holdn};

  hold_gate_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign lvl = {pins_s.csn, pins_s.sclk, pins_s.holdn};

  hold_gate_edge #(
    .WIDTH   (EDGE_W),
    .RST_VAL ({PIN_IDLE.csn, PIN_IDLE.sclk, PIN_IDLE.holdn})
  ) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  assign sel = ~pins_s.csn;

  hold_gate_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .selected  (sel),
    .sclk_lvl  (pins_s.sclk),
    .sclk_fall (fall[1]),
    .hold_fall (fall[0]),
    .hold_rise (rise[0]),
    .state     (st)
  );

  assign paused          = st.held;
  assign core_rise_en    = rise[1] & sel & ~st.held;
  assign core_fall_en    = fall[1] & sel & ~st.held;
  assign core_sdi        = pins_s.sdi;
  assign core_selected   = sel;
  assign core_xfer_done  = rise[2] & ~st.held;
  assign core_xfer_abort = rise[2] & st.held;
  assign sdo_oe          = core_drive_req & sel & ~st.held;

endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic paused,
  input logic core_rise_en,
  input logic core_fall_en,
  input logic core_selected,
  input logic core_xfer_done,
  input logic core_xfer_abort,
  input logic sdo_oe
);

  AST_NO_EDGE_WHEN_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (!core_rise_en && !core_fall_en)); // R6

  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !core_selected |=> !paused); // R8

  AST_PAUSE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(core_selected)); // R8

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_xfer_done && core_xfer_abort)); // R9

  AST_ABORT_ONLY_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    core_xfer_abort |-> paused); // R9

  AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (paused || !core_selected) |-> !sdo_oe); // R7

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_rise_en |=> !core_rise_en); // R10

endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .paused          (paused),
  .core_rise_en    (core_rise_en),
  .core_fall_en    (core_fall_en),
  .core_selected   (core_selected),
  .core_xfer_done  (core_xfer_done),
  .core_xfer_abort (core_xfer_abort),
  .sdo_oe          (sdo_oe)
);

// File: tb/spi_hold_gate_tb_top.sv
`timescale 1ns/1ps
module spi_hold_gate_tb_top;

  localparam int STAGES = 3;
  localparam int STEP   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0, holdn = 1'b1, drv = 1'b0;
  logic paused, rise_en, fall_en, core_sdi, core_sel, xdone, xabort, oe;

  always #4 clk = ~clk;  // 125 MHz

  spi_hold_gate #(.SYNC_STAGES(STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk), .spi_sdi(sdi),
    .spi_holdn(holdn), .core_drive_req(drv), .paused(paused),
    .core_rise_en(rise_en), .core_fall_en(fall_en), .core_sdi(core_sdi),
    .core_selected(core_sel), .core_xfer_done(xdone),
    .core_xfer_abort(xabort), .sdo_oe(oe)
  );

  int n_chk = 0, n_fail = 0;
  int c_rise = 0, c_fall = 0, c_done = 0, c_abort = 0;
  bit finished = 0;

  always @(negedge clk) if (rst_n) begin
    c_rise  += int'(rise_en);
    c_fall  += int'(fall_en);
    c_done  += int'(xdone);
    c_abort += int'(xabort);
  end

  // reference model state
  logic m_held = 0, m_pe = 0, m_px = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_oe(logic d, logic c, logic h);
    return int'(d & ~c & ~h);
  endfunction

  task automatic step(logic n_cs, logic n_sclk, logic n_sdi, logic n_hold, logic n_drv, string tag);
    int r0, f0, d0, a0, er, ef, ed, ea;
    r0 = c_rise; f0 = c_fall; d0 = c_done; a0 = c_abort;
    er = 0; ef = 0; ed = 0; ea = 0;
    if (n_cs && !csn) begin
      ed = int'(!m_held); ea = int'(m_held);
      m_held = 0; m_pe = 0; m_px = 0;
    end else if (!n_cs && !csn) begin
      if (!n_hold && holdn) begin
        if (!sclk) begin m_held = 1; m_pe = 0; end else m_pe = 1;
        m_px = 0;
      end else if (n_hold && !holdn) begin
        if (!sclk) begin m_held = 0; m_px = 0; end else m_px = 1;
        m_pe = 0;
      end else if (n_sclk && !sclk) begin
        er = int'(!m_held);
      end else if (!n_sclk && sclk) begin
        ef = int'(!m_held);
        if (m_pe) begin m_held = 1; m_pe = 0; end
        else if (m_px) begin m_held = 0; m_px = 0; end
      end
    end
    @(negedge clk); #1;
    csn = n_cs; sclk = n_sclk; sdi = n_sdi; holdn = n_hold; drv = n_drv;
    repeat (STEP) @(negedge clk);
    #1;
    check({tag, " R2 paused"}, int'(paused), int'(m_held));
    check({tag, " R7 sdo_oe"}, int'(oe), exp_oe(drv, csn, m_held));
    check({tag, " R10 rise"}, c_rise - r0, er);
    check({tag, " R6 fall"}, c_fall - f0, ef);
    check({tag, " R9 done"}, c_done - d0, ed);
    check({tag, " R9 abort"}, c_abort - a0, ea);
    check({tag, " R11 sdi"}, int'(core_sdi), int'(sdi));
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int sel_v;
    logic ncs, nsc, nsd, nho, ndr;
    repeat (3) @(negedge clk);
    #1;
    check("R1 paused", int'(paused), 0);
    check("R1 oe", int'(oe), 0);
    check("R1 sel", int'(core_sel), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 rise", int'(rise_en), 0);
    check("R1 done", int'(xdone), 0);

    // R8: pause edge while deselected is ignored
    step(1, 0, 0, 0, 1, "R8 desel");
    step(0, 0, 0, 0, 1, "R8 select_low");
    step(0, 0, 0, 1, 1, "R8 rel");
    // R2 latency directed
    @(negedge clk); #1; holdn = 0; m_held = 1;
    repeat (STAGES) @(negedge clk);
    #1; check("R2 before", int'(paused), 0);
    @(negedge clk); #1; check("R2 after", int'(paused), 1);
    repeat (STEP) @(negedge clk);
    step(0, 1, 1, 0, 1, "R6 held_rise");
    step(0, 0, 1, 0, 1, "R6 held_fall");
    step(0, 0, 1, 1, 1, "R4 release_low");
    step(0, 1, 0, 1, 1, "R10 rise");
    step(0, 1, 0, 0, 1, "R3 enter_high");
    step(0, 0, 0, 0, 1, "R3 enter_fall");
    step(0, 1, 0, 0, 1, "R5 held_high");
    step(0, 1, 0, 1, 1, "R5 exit_high");
    step(0, 0, 0, 1, 1, "R5 exit_fall");
    step(0, 0, 0, 0, 0, "R2 enter_low");
    step(1, 0, 0, 0, 0, "R9 abort");
    step(0, 0, 0, 1, 1, "R9 sel");
    step(1, 0, 0, 1, 1, "R9 done");

    void'($urandom(32'd2024));
    for (int i = 0; i < 1500; i++) begin
      ncs = csn; nsc = sclk; nsd = sdi; nho = holdn;
      ndr = $urandom_range(0, 1);
      sel_v = $urandom_range(0, 99);
      if (sel_v < 8)       ncs = ~csn;
      else if (sel_v < 33) nho = ~holdn;
      else if (sel_v < 85) nsc = ~sclk;
      else                 nsd = ~sdi;
      step(ncs, nsc, nsd, nho, ndr, "R6 rand");
    end

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule